// File: doc/BRIEF.md
# Clock Generator Start-up Controller

This block is the control and status logic that brings up a clock generator made of a crystal oscillator and a frequency-multiplying loop. Software programs one mode register to switch the oscillator on, to bypass it in favour of an external clock, to set the oscillator settling count, to pick the loop multiplier and to set the lock wait. The block drives the enables of the analog oscillator and of the multiplier loop, and it reports two status flags: oscillator stable and loop locked.

Both waits are measured against a slow reference clock. That clock enters as `slow_tick`, a one-cycle strobe in the bus clock domain for each slow-clock period. The oscillator wait is a loaded count that steps down once every eight slow ticks. The lock wait is a second count that steps down on every slow tick. A multiplier of zero also acts as the power-down control of the loop.

Each flag has its own interrupt enable. The interrupt output is a registered OR of the flags whose enables are set.

Top module: `clkgen_startup_ctrl`

## Requirements
- R1: After reset, `osc_en_o`, `ext_clk_sel_o`, `pll_en_o` and `irq_o` are 0, `pll_ratio_o` is 1, both status flags are 0, and every register reads 0.
- R2: The mode register is at address 0. Its fields are: oscillator-on at bit 0, bypass at bit 1, settling count at bits 15:8, multiplier at bits 21:16 and lock count at bits 29:24. All other bits read 0. `rdata` shows the register selected by `addr` one clock after `addr` is presented, and it shows the contents held before any write made in that same cycle.
- R3: After a mode write, `osc_en_o` equals oscillator-on AND NOT bypass. It changes on the clock edge that accepts the write.
- R4: A mode write with oscillator-on = 1 and bypass = 0 clears the stable flag and loads the settling count N. The flag then sets on the 8·N-th slow tick after the write, or on the first slow tick when N = 0. A slow tick in the same cycle as the write is not counted.
- R5: A mode write with oscillator-on = 0 clears the stable flag at the edge that accepts the write, and it abandons any settling count in progress.
- R6: A mode write with oscillator-on = 1 and bypass = 1 sets the stable flag at the accepting edge, with no wait. `ext_clk_sel_o` follows the bypass bit.
- R7: `pll_en_o` is 1 exactly when the multiplier field is nonzero. `pll_ratio_o` is the multiplier plus one, in the range 1 to 64.
- R8: A mode write that changes the multiplier clears the lock flag. If the new multiplier is nonzero, the lock flag sets on the M-th slow tick after the write, where M is the lock count, or on the first slow tick when M = 0. A mode write that leaves the multiplier unchanged does not affect the lock flag or its countdown.
- R9: The status register is at address 1, with the stable flag at bit 0 and the lock flag at bit 1. Writes to it have no effect.
- R10: The interrupt-enable register is at address 2, with the stable-flag enable at bit 0 and the lock-flag enable at bit 1. `irq_o` is the OR of the enabled flags, registered so that it follows a flag or enable change by one clock.
- R11: Address 3 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and control clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle strobe per slow reference clock period |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (2) | Register address for write and read |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Registered read data for `addr` |
| osc_en_o | output | 1 | Enable to the analog oscillator |
| ext_clk_sel_o | output | 1 | Selects the external input as the oscillator output |
| pll_en_o | output | 1 | Enable to the multiplier loop |
| pll_ratio_o | output | MUL_W+1 (7) | Multiplication ratio, multiplier field plus one |
| irq_o | output | 1 | Level interrupt, OR of enabled flags |

## Verification
The hardest situation to reach is a write that lands in the same cycle as a slow tick while a countdown is running. The write must win, and the coinciding tick must not be counted. The bench drives `slow_tick` with a fixed pattern whose period does not divide into the spacing of its writes, so over the run many writes fall on a tick. A behavioural model that counts remaining slow ticks is compared with every output on every clock. The bench also issues mode writes that leave the multiplier unchanged while a lock wait is running, and clears the oscillator partway through a wait, so the abandon and no-effect paths are both checked against the model.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  // mode register field positions (decoded by software, so fixed)
  localparam int OSC_ON_BIT   = 0;
  localparam int BYPASS_BIT   = 1;
  localparam int OSC_CNT_LSB  = 8;
  localparam int MUL_LSB      = 16;
  localparam int LOCK_CNT_LSB = 24;

  // status and interrupt-enable bit positions
  localparam int ST_READY_BIT = 0;
  localparam int ST_LOCK_BIT  = 1;
  localparam int NUM_FLAGS    = 2;

  typedef enum logic [1:0] {
    SEL_MODE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_IRQEN  = 2'd2,
    SEL_SPARE  = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/clkgen_regs.sv
module clkgen_regs
  import clkgen_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int OSC_CNT_W = 8,
  parameter int MUL_W     = 6,
  parameter int LOCK_W    = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 osc_ready,
  input  logic                 pll_lock,
  output logic                 mode_wr,
  output logic                 mul_change,
  output logic                 wr_on,
  output logic                 wr_bypass,
  output logic [OSC_CNT_W-1:0] wr_osc_cnt,
  output logic [MUL_W-1:0]     wr_mul,
  output logic [LOCK_W-1:0]    wr_lock_cnt,
  output logic [MUL_W-1:0]     mul_q,
  output logic [NUM_FLAGS-1:0] irq_en,
  output logic                 osc_en_o,
  output logic                 ext_clk_sel_o,
  output logic                 pll_en_o,
  output logic [MUL_W:0]       pll_ratio_o,
  output logic [DATA_W-1:0]    rdata
);

  localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(SEL_MODE);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(SEL_STATUS);
  localparam logic [ADDR_W-1:0] A_IRQEN  = ADDR_W'(SEL_IRQEN);

  logic                 on_q;
  logic                 bypass_q;
  logic [OSC_CNT_W-1:0] osc_cnt_q;
  logic [LOCK_W-1:0]    lock_cnt_q;
  logic                 ien_wr;
  logic [DATA_W-1:0]    rd_mux;

  // field extraction from the write bus
  assign mode_wr     = wr_en && (addr == A_MODE);
  assign ien_wr      = wr_en && (addr == A_IRQEN);
  assign wr_on       = wdata[OSC_ON_BIT];
  assign wr_bypass   = wdata[BYPASS_BIT];
  assign wr_osc_cnt  = wdata[OSC_CNT_LSB +: OSC_CNT_W];
  assign wr_mul      = wdata[MUL_LSB +: MUL_W];
  assign wr_lock_cnt = wdata[LOCK_CNT_LSB +: LOCK_W];
  assign mul_change  = mode_wr && (wr_mul != mul_q);

  // mode register and the outputs derived from it
  always_ff @(posedge clk) begin
    if (rst) begin
      on_q          <= 1'b0;
      bypass_q      <= 1'b0;
      osc_cnt_q     <= '0;
      mul_q         <= '0;
      lock_cnt_q    <= '0;
      osc_en_o      <= 1'b0;
      ext_clk_sel_o <= 1'b0;
      pll_en_o      <= 1'b0;
      pll_ratio_o   <= (MUL_W+1)'(1);
    end else if (mode_wr) begin
      on_q          <= wr_on;
      bypass_q      <= wr_bypass;
      osc_cnt_q     <= wr_osc_cnt;
      mul_q         <= wr_mul;
      lock_cnt_q    <= wr_lock_cnt;
      osc_en_o      <= wr_on && !wr_bypass;
      ext_clk_sel_o <= wr_bypass;
      pll_en_o      <= (wr_mul != '0);
      pll_ratio_o   <= {1'b0, wr_mul} + (MUL_W+1)'(1);
    end
  end

  // interrupt enables
  always_ff @(posedge clk) begin
    if (rst)         irq_en <= '0;
    else if (ien_wr) irq_en <= wdata[NUM_FLAGS-1:0];
  end

  // read mux
  always_comb begin
    rd_mux = '0;
    case (addr)
      A_MODE: begin
        rd_mux[OSC_ON_BIT]                  = on_q;
        rd_mux[BYPASS_BIT]                  = bypass_q;
        rd_mux[OSC_CNT_LSB +: OSC_CNT_W]    = osc_cnt_q;
        rd_mux[MUL_LSB +: MUL_W]            = mul_q;
        rd_mux[LOCK_CNT_LSB +: LOCK_W]      = lock_cnt_q;
      end
      A_STATUS: begin
        rd_mux[ST_READY_BIT] = osc_ready;
        rd_mux[ST_LOCK_BIT]  = pll_lock;
      end
      A_IRQEN: rd_mux[NUM_FLAGS-1:0] = irq_en;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

endmodule

// File: rtl/osc_settle_timer.sv
module osc_settle_timer #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             load_on,
  input  logic             load_bypass,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             tick,
  output logic             ready
);

  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] pre;
  logic             run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pre   <= '0;
      run   <= 1'b0;
      ready <= 1'b0;
    end else if (load) begin
      cnt <= load_cnt;
      pre <= '0;
      if (!load_on) begin
        run   <= 1'b0;
        ready <= 1'b0;
      end else if (load_bypass) begin
        run   <= 1'b0;
        ready <= 1'b1;
      end else begin
        run   <= 1'b1;
        ready <= 1'b0;
      end
    end else if (run && tick) begin
      if (cnt == '0) begin
        run   <= 1'b0;
        ready <= 1'b1;
      end else begin
        pre <= pre + 1'b1;
        if (&pre) begin
          cnt <= cnt - 1'b1;
          if (cnt == CNT_W'(1)) begin
            run   <= 1'b0;
            ready <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             arm,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             tick,
  output logic             locked
);

  logic [CNT_W-1:0] cnt;
  logic             run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      run    <= 1'b0;
      locked <= 1'b0;
    end else if (restart) begin
      cnt    <= load_cnt;
      run    <= arm;
      locked <= 1'b0;
    end else if (run && tick) begin
      if (cnt <= CNT_W'(1)) begin
        run    <= 1'b0;
        locked <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/clkgen_startup_ctrl.sv
module clkgen_startup_ctrl
  import clkgen_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int OSC_CNT_W = 8,
  parameter int PRE_W     = 3,
  parameter int MUL_W     = 6,
  parameter int LOCK_W    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              osc_en_o,
  output logic              ext_clk_sel_o,
  output logic              pll_en_o,
  output logic [MUL_W:0]    pll_ratio_o,
  output logic              irq_o
);

  logic                 mode_wr;
  logic                 mul_change;
  logic                 wr_on;
  logic                 wr_bypass;
  logic [OSC_CNT_W-1:0] wr_osc_cnt;
  logic [MUL_W-1:0]     wr_mul;
  logic [LOCK_W-1:0]    wr_lock_cnt;
  logic [MUL_W-1:0]     mul_q;
  logic [NUM_FLAGS-1:0] irq_en;
  logic                 osc_ready;
  logic                 pll_lock;
  logic [NUM_FLAGS-1:0] flags;

  clkgen_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OSC_CNT_W(OSC_CNT_W),
    .MUL_W(MUL_W), .LOCK_W(LOCK_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .osc_ready(osc_ready), .pll_lock(pll_lock),
    .mode_wr(mode_wr), .mul_change(mul_change),
    .wr_on(wr_on), .wr_bypass(wr_bypass), .wr_osc_cnt(wr_osc_cnt),
    .wr_mul(wr_mul), .wr_lock_cnt(wr_lock_cnt), .mul_q(mul_q),
    .irq_en(irq_en), .osc_en_o(osc_en_o), .ext_clk_sel_o(ext_clk_sel_o),
    .pll_en_o(pll_en_o), .pll_ratio_o(pll_ratio_o), .rdata(rdata)
  );

  osc_settle_timer #(.CNT_W(OSC_CNT_W), .PRE_W(PRE_W)) u_osc (
    .clk(clk), .rst(rst), .load(mode_wr), .load_on(wr_on),
    .load_bypass(wr_bypass), .load_cnt(wr_osc_cnt), .tick(slow_tick),
    .ready(osc_ready)
  );

  pll_lock_timer #(.CNT_W(LOCK_W)) u_lock (
    .clk(clk), .rst(rst), .restart(mul_change), .arm(wr_mul != '0),
    .load_cnt(wr_lock_cnt), .tick(slow_tick), .locked(pll_lock)
  );

  assign flags[ST_READY_BIT] = osc_ready;
  assign flags[ST_LOCK_BIT]  = pll_lock;

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(flags & irq_en);
  end

endmodule

// File: rtl/clkgen_startup_chk.sv
module clkgen_startup_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int MUL_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [MUL_W-1:0]  mul_q,
  input logic              osc_ready,
  input logic              pll_lock,
  input logic [1:0]        irq_en,
  input logic              osc_en_o,
  input logic              ext_clk_sel_o,
  input logic              pll_en_o,
  input logic              irq_o
);

  logic mode_wr;
  assign mode_wr = wr_en && (addr == ADDR_W'(0));

  assert_osc_off_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && !wdata[0]) |=> !osc_ready);

  assert_ready_needs_on_R4: assert property (@(posedge clk) disable iff (rst)
    osc_ready |-> (osc_en_o || ext_clk_sel_o));

  assert_bypass_gates_osc_R3: assert property (@(posedge clk) disable iff (rst)
    ext_clk_sel_o |-> !osc_en_o);

  assert_bypass_ready_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && wdata[0] && wdata[1]) |=> osc_ready);

  assert_lock_needs_pll_R7: assert property (@(posedge clk) disable iff (rst)
    pll_lock |-> pll_en_o);

  assert_mul_change_unlocks_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && (wdata[16 +: MUL_W] != mul_q)) |=> !pll_lock);

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (!(osc_ready && irq_en[0]) && !(pll_lock && irq_en[1])) |=> !irq_o);

endmodule

bind clkgen_startup_ctrl clkgen_startup_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MUL_W(MUL_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .mul_q(mul_q), .osc_ready(osc_ready), .pll_lock(pll_lock),
  .irq_en(irq_en), .osc_en_o(osc_en_o), .ext_clk_sel_o(ext_clk_sel_o),
  .pll_en_o(pll_en_o), .irq_o(irq_o)
);

// File: tb/clkgen_startup_ctrl_test.sv
module clkgen_startup_ctrl_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slow_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd1;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        osc_en_o, ext_clk_sel_o, pll_en_o, irq_o;
  logic [6:0]  pll_ratio_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  clkgen_startup_ctrl uut (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .osc_en_o(osc_en_o),
    .ext_clk_sel_o(ext_clk_sel_o), .pll_en_o(pll_en_o),
    .pll_ratio_o(pll_ratio_o), .irq_o(irq_o)
  );

  // behavioural reference model
  int m_on, m_byp, m_cnt, m_mul, m_lcnt, m_ie;
  int m_ready, m_lock, m_irq, m_osc_run, m_lock_run;
  int osc_left, lock_left;
  logic [31:0] m_rdata;

  function automatic logic [31:0] mode_word();
    logic [31:0] w;
    w = '0;
    w[0] = m_on[0];
    w[1] = m_byp[0];
    w[15:8] = m_cnt[7:0];
    w[21:16] = m_mul[5:0];
    w[29:24] = m_lcnt[5:0];
    return w;
  endfunction

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      m_on = 0; m_byp = 0; m_cnt = 0; m_mul = 0; m_lcnt = 0; m_ie = 0;
      m_ready = 0; m_lock = 0; m_irq = 0; m_osc_run = 0; m_lock_run = 0;
      osc_left = 0; lock_left = 0; m_rdata = '0;
    end else begin
      int irq_n, nmul;
      case (addr)
        2'd0: m_rdata = mode_word();
        2'd1: m_rdata = {30'd0, m_lock[0], m_ready[0]};
        2'd2: m_rdata = {30'd0, m_ie[1:0]};
        default: m_rdata = '0;
      endcase
      irq_n = ((m_ready != 0) && m_ie[0]) || ((m_lock != 0) && m_ie[1]) ? 1 : 0;
      nmul = int'(wdata[21:16]);
      if (wr_en && addr == 2'd0) begin
        if (!wdata[0]) begin
          m_ready = 0; m_osc_run = 0;
        end else if (wdata[1]) begin
          m_ready = 1; m_osc_run = 0;
        end else begin
          m_ready = 0; m_osc_run = 1;
          osc_left = (wdata[15:8] == 0) ? 1 : 8 * int'(wdata[15:8]);
        end
      end else if (m_osc_run != 0 && slow_tick) begin
        osc_left = osc_left - 1;
        if (osc_left == 0) begin m_ready = 1; m_osc_run = 0; end
      end
      if (wr_en && addr == 2'd0 && nmul != m_mul) begin
        m_lock = 0;
        m_lock_run = (nmul != 0) ? 1 : 0;
        lock_left = (wdata[29:24] == 0) ? 1 : int'(wdata[29:24]);
      end else if (m_lock_run != 0 && slow_tick) begin
        lock_left = lock_left - 1;
        if (lock_left == 0) begin m_lock = 1; m_lock_run = 0; end
      end
      if (wr_en && addr == 2'd0) begin
        m_on = int'(wdata[0]); m_byp = int'(wdata[1]);
        m_cnt = int'(wdata[15:8]); m_mul = nmul; m_lcnt = int'(wdata[29:24]);
      end
      if (wr_en && addr == 2'd2) m_ie = int'(wdata[1:0]);
      m_irq = irq_n;
    end
  end

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [1:0] last_addr;
      check(osc_en_o == ((m_on != 0) && (m_byp == 0)), "R3 osc_en_o", osc_en_o, (m_on != 0) && (m_byp == 0));
      check(ext_clk_sel_o == (m_byp != 0), "R6 ext_clk_sel_o", ext_clk_sel_o, m_byp);
      check(pll_en_o == (m_mul != 0), "R7 pll_en_o", pll_en_o, m_mul != 0);
      check(pll_ratio_o == 7'(m_mul + 1), "R7 pll_ratio_o", pll_ratio_o, m_mul + 1);
      check(irq_o == (m_irq != 0), "R10 irq_o", irq_o, m_irq);
      check(rdata == m_rdata, "R2 R4 R5 R8 R9 R11 rdata", rdata, m_rdata);
      last_addr = addr;
    end
  end

  // slow reference strobe: one cycle in three, changed away from the edge
  always @(negedge clk) slow_tick <= (cyc % 3 == 1);

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd1; wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] mw(input int on, input int byp, input int cnt,
                                     input int mul, input int lcnt);
    return {2'b0, 6'(lcnt), 2'b0, 6'(mul), 8'(cnt), 6'b0, 1'(byp), 1'(on)};
  endfunction

  // read a register; rdata is valid at the negedge after addr is presented
  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    v = rdata;
    addr = 2'd1;
  endtask

  logic [31:0] v;

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state, sampled while still in reset after clocks
    check(osc_en_o == 0 && ext_clk_sel_o == 0 && pll_en_o == 0 && irq_o == 0,
          "R1 enables after reset", {osc_en_o, ext_clk_sel_o, pll_en_o, irq_o}, 0);
    check(pll_ratio_o == 7'd1, "R1 ratio after reset", pll_ratio_o, 1);
    rst = 1'b0;
    rd(2'd0, v); check(v == 0, "R1 mode reads 0", v, 0);
    rd(2'd1, v); check(v == 0, "R1 status reads 0", v, 0);

    wr(2'd2, 32'h3);
    rd(2'd2, v); check(v == 32'h3, "R10 irq enable readback", v, 3);

    // R4 settling count 3 => 24 slow ticks (72 cycles)
    wr(2'd0, mw(1, 0, 3, 0, 0));
    idle(40);
    rd(2'd1, v); check(v[0] == 0, "R4 not stable mid-count", v[0], 0);
    idle(50);
    rd(2'd1, v); check(v[0] == 1, "R4 stable after count", v[0], 1);
    check(irq_o == 1, "R10 irq from stable flag", irq_o, 1);

    // R8 lock with multiplier 5, lock count 10
    wr(2'd0, mw(1, 0, 2, 5, 10));
    idle(60);
    rd(2'd1, v); check(v == 32'h3, "R8 locked and R4 stable", v, 3);
    check(pll_ratio_o == 7'd6, "R7 ratio mul+1", pll_ratio_o, 6);

    // R8 same multiplier: lock untouched; R4 count 0 -> first tick
    wr(2'd0, mw(1, 0, 0, 5, 1));
    rd(2'd1, v); check(v[1] == 1, "R8 unchanged mul keeps lock", v[1], 1);
    idle(5);
    rd(2'd1, v); check(v[0] == 1, "R4 zero count stable on first tick", v[0], 1);

    // R5 abandon mid-count
    wr(2'd0, mw(1, 0, 5, 5, 1));
    idle(20);
    wr(2'd0, mw(0, 0, 5, 5, 1));
    idle(150);
    rd(2'd1, v); check(v[0] == 0, "R5 stable stays clear after off", v[0], 0);

    // R6 bypass, R7 max multiplier, lock count 0
    wr(2'd0, mw(1, 1, 9, 63, 0));
    rd(2'd1, v); check(v[0] == 1, "R6 bypass stable at once", v[0], 1);
    check(osc_en_o == 0 && ext_clk_sel_o == 1, "R6 bypass gates osc", {osc_en_o, ext_clk_sel_o}, 1);
    check(pll_ratio_o == 7'd64, "R7 ratio 64", pll_ratio_o, 64);
    idle(6);

    // R7 multiplier 0 powers the loop down and clears lock
    wr(2'd0, mw(1, 1, 9, 0, 4));
    rd(2'd1, v); check(v[1] == 0 && pll_en_o == 0, "R7 mul zero disables", {v[1], pll_en_o}, 0);
    idle(20);
    rd(2'd1, v); check(v[1] == 0, "R8 no lock with mul zero", v[1], 0);

    // R9 status write ignored; R11 spare address
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); check(v == 32'h1, "R9 status write ignored", v, 1);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); check(v == 0, "R11 spare reads 0", v, 0);
    rd(2'd0, v); check(v == mw(1, 1, 9, 0, 4), "R2 mode readback", v, mw(1, 1, 9, 0, 4));

    // R10 only lock enabled
    wr(2'd2, 32'h2);
    idle(2);
    check(irq_o == 0, "R10 masked stable flag", irq_o, 0);
    wr(2'd0, mw(1, 0, 1, 7, 2));
    idle(30);
    check(irq_o == 1, "R10 irq from lock", irq_o, 1);

    // back-to-back writes that collide with ticks
    for (int i = 0; i < 20; i++) begin
      wr(2'd0, mw(1, i % 2, i % 4, (i % 3) * 9, i % 5));
      idle(i % 7);
    end
    idle(200);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule